// File: doc/BRIEF.md
# Row-Sequential Binary Frame Readout Controller

This block reads out a binary pixel array, 128 rows by 512 columns with one bit per pixel, one row at a time. For each row it drives a row address together with a row select and a column output enable. In the same cycle it latches the full row of column values into a row register. It then sends that register out as a series of narrower pixel words. Each word is tagged with its row index and its beat index.

The controller is a three-stage pipeline: row select, row capture, then multiplexed transfer. The next row is selected and captured while the previous row is still being sent, so pixel words leave the block back to back for the whole frame. When a row is deselected after its capture, the block pulses a reset for that row, which clears its in-pixel memories. The array keeps detecting photons between row reads, so a row can collect new events as soon as it has been reset.

A start pulse begins a frame. Any start that arrives while a frame is still in progress is ignored. A frame-done pulse follows the last word of the last row, and the next frame begins again at row 0.

Top module: `frame_readout_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, row_sel_o, out_en_o, row_rst_o, pix_valid_o and frame_done_o are all 0.
- R2: A start_i that is high at a clock edge while no frame is in progress makes row_sel_o and out_en_o high in the next cycle, with row_addr_o = 0. This holds for every frame, including those that follow a completed frame.
- R3: Within a frame, rows are selected in ascending order from 0 to 127. Each select lasts exactly one cycle, and consecutive selects are exactly 4 cycles apart.
- R4: The row on col_data_i is captured in its select cycle and sent as 4 beats with pix_beat_o = 0,1,2,3 on consecutive cycles. Beat b carries columns 128*b to 128*b+127, with column 128*b in bit 0 of pix_data_o. Beat 0 appears 2 cycles after the row's select cycle, tagged with that row in pix_row_o.
- R5: In the cycle after each row select, row_rst_o is high for exactly one cycle and row_rst_addr_o carries the deselected row. Rows that were read and not exposed again return all-zero data in the next frame.
- R6: The next row is selected while the current row is still being sent. A frame's 512 beats are therefore output on 512 consecutive cycles.
- R7: frame_done_o is high for exactly one cycle: the cycle right after the beat with row 127 and beat 3.
- R8: A start_i that arrives while a frame is in progress, up to and including the frame_done_o cycle, is ignored. The frame still outputs exactly 512 beats, and after frame_done_o no row is selected and no beat is output until a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a frame when idle |
| row_addr_o | output | 7 | Selected row address |
| row_sel_o | output | 1 | Row select strobe |
| out_en_o | output | 1 | Column output enable |
| col_data_i | input | 512 | Column values of the selected row |
| row_rst_o | output | 1 | In-pixel memory reset pulse for the deselected row |
| row_rst_addr_o | output | 7 | Row that row_rst_o clears |
| pix_valid_o | output | 1 | Pixel word valid |
| pix_data_o | output | 128 | Pixel word, one bit per column |
| pix_row_o | output | 7 | Row index of the word |
| pix_beat_o | output | 2 | Beat index within the row |
| frame_done_o | output | 1 | One-cycle pulse after the last beat of a frame |

## Verification
The bench uses a behavioural array that clears a row on each reset pulse and takes pattern loads and OR-style exposures. Each beat is compared with the bench's own copy of the array contents.

The first frame uses a distinct pseudo-random pattern in every row and column group. It shows that the rows and beats come out in the right order and that the column slices are placed correctly.

The second frame runs without any new exposure and must read all zeros. This shows that every row was reset after its read.

A third frame receives an exposure into already-read rows while it is still running. The fourth frame must then show only those rows with data, which shows that exposure and readout overlap. Starts sent in the middle of a frame and in the frame-done cycle must cause neither an extra frame nor any select.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rdo_row_seq.sv
module rdo_row_seq
  import rdo_pkg::*;
#(
  parameter int N_ROWS = 128,
  parameter int BEATS  = 4,
  localparam int RW = $clog2(N_ROWS),
  localparam int PW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          frame_done_i,
  output logic          row_sel_o,
  output logic [RW-1:0] row_addr_o
);

  seq_state_e    state_q;
  logic [PW-1:0] ph_q;
  logic [RW-1:0] addr_q;
  logic          sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      addr_q  <= '0;
      sel_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          sel_q <= 1'b0;
          if (start_i) begin
            state_q <= ST_SCAN;
            sel_q   <= 1'b1;
            addr_q  <= '0;
            ph_q    <= '0;
          end
        end
        ST_SCAN: begin
          if (ph_q == PW'(BEATS - 1)) begin
            ph_q <= '0;
            if (addr_q == RW'(N_ROWS - 1)) begin
              state_q <= ST_DRAIN;
              sel_q   <= 1'b0;
              addr_q  <= '0;  // wrap for the next frame
            end else begin
              sel_q  <= 1'b1;
              addr_q <= addr_q + 1'b1;
            end
          end else begin
            ph_q  <= ph_q + 1'b1;
            sel_q <= 1'b0;
          end
        end
        ST_DRAIN: begin
          sel_q <= 1'b0;
          if (frame_done_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign row_sel_o  = sel_q;
  assign row_addr_o = addr_q;

  a_r2_start_row0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q == ST_IDLE) |=> (sel_q && addr_q == '0));

  a_r8_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q != ST_IDLE) |=> !(sel_q && addr_q == '0));

  a_r3_sel_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q |=> !sel_q);

endmodule

// File: rtl/rdo_row_capture.sv
module rdo_row_capture #(
  parameter int N_ROWS = 128,
  parameter int N_COLS = 512,
  localparam int RW = $clog2(N_ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              row_sel_i,
  input  logic [RW-1:0]     row_addr_i,
  input  logic [N_COLS-1:0] col_data_i,
  output logic [N_COLS-1:0] row_data_o,
  output logic              cap_vld_o,
  output logic [RW-1:0]     cap_row_o
);

  logic [N_COLS-1:0] data_q;
  logic              vld_q;
  logic [RW-1:0]     row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= 1'b0;
      row_q  <= '0;
    end else begin
      vld_q <= row_sel_i;
      if (row_sel_i) begin
        data_q <= col_data_i;
        row_q  <= row_addr_i;
      end
    end
  end

  assign row_data_o = data_q;
  assign cap_vld_o  = vld_q;
  assign cap_row_o  = row_q;

  // capture strobe doubles as the deselect reset pulse
  a_r5_rst_after_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_sel_i |=> (vld_q && row_q == $past(row_addr_i)));

endmodule

// File: rtl/rdo_beat_mux.sv
module rdo_beat_mux #(
  parameter int N_ROWS = 128,
  parameter int N_COLS = 512,
  parameter int OUT_W  = 128,
  localparam int RW    = $clog2(N_ROWS),
  localparam int BEATS = N_COLS / OUT_W,
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_COLS-1:0] row_data_i,
  input  logic              cap_vld_i,
  input  logic [RW-1:0]     cap_row_i,
  output logic              pix_valid_o,
  output logic [OUT_W-1:0]  pix_data_o,
  output logic [RW-1:0]     pix_row_o,
  output logic [BW-1:0]     pix_beat_o,
  output logic              frame_done_o
);

  localparam logic [RW-1:0] LAST_ROW  = RW'(N_ROWS - 1);
  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

  logic [OUT_W-1:0] slice [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_slice
    assign slice[g] = row_data_i[g*OUT_W +: OUT_W];
  end

  logic          act_q;
  logic [BW-1:0] nxt_q;
  logic          vld_q;
  logic [OUT_W-1:0] data_q;
  logic [RW-1:0] row_q;
  logic [BW-1:0] beat_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      nxt_q  <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
      row_q  <= '0;
      beat_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= vld_q && row_q == LAST_ROW && beat_q == LAST_BEAT;
      if (cap_vld_i) begin
        vld_q  <= 1'b1;
        data_q <= slice[0];
        row_q  <= cap_row_i;
        beat_q <= '0;
        nxt_q  <= BW'(1);
        act_q  <= (BEATS > 1);
      end else if (act_q) begin
        vld_q  <= 1'b1;
        data_q <= slice[nxt_q];
        beat_q <= nxt_q;
        if (nxt_q == LAST_BEAT) act_q <= 1'b0;
        else nxt_q <= nxt_q + 1'b1;
      end else begin
        vld_q <= 1'b0;
      end
    end
  end

  assign pix_valid_o  = vld_q;
  assign pix_data_o   = data_q;
  assign pix_row_o    = row_q;
  assign pix_beat_o   = beat_q;
  assign frame_done_o = done_q;

  a_r4_beat_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && beat_q != LAST_BEAT) |=>
      (vld_q && beat_q == $past(beat_q) + 1'b1 && row_q == $past(row_q)));

  a_r6_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && beat_q == LAST_BEAT && row_q != LAST_ROW) |=>
      (vld_q && beat_q == '0 && row_q == $past(row_q) + 1'b1));

  a_r7_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(vld_q && row_q == LAST_ROW && beat_q == LAST_BEAT));

endmodule

// File: rtl/frame_readout_ctrl.sv
module frame_readout_ctrl #(
  parameter int N_ROWS = 128,
  parameter int N_COLS = 512,
  parameter int OUT_W  = 128,
  localparam int RW    = $clog2(N_ROWS),
  localparam int BEATS = N_COLS / OUT_W,
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [RW-1:0]     row_addr_o,
  output logic              row_sel_o,
  output logic              out_en_o,
  input  logic [N_COLS-1:0] col_data_i,
  output logic              row_rst_o,
  output logic [RW-1:0]     row_rst_addr_o,
  output logic              pix_valid_o,
  output logic [OUT_W-1:0]  pix_data_o,
  output logic [RW-1:0]     pix_row_o,
  output logic [BW-1:0]     pix_beat_o,
  output logic              frame_done_o
);

  logic              sel;
  logic [RW-1:0]     addr;
  logic [N_COLS-1:0] row_data;
  logic              cap_vld;
  logic [RW-1:0]     cap_row;
  logic              done;

  rdo_row_seq #(.N_ROWS(N_ROWS), .BEATS(BEATS)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .frame_done_i (done),
    .row_sel_o    (sel),
    .row_addr_o   (addr)
  );

  rdo_row_capture #(.N_ROWS(N_ROWS), .N_COLS(N_COLS)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .row_sel_i  (sel),
    .row_addr_i (addr),
    .col_data_i (col_data_i),
    .row_data_o (row_data),
    .cap_vld_o  (cap_vld),
    .cap_row_o  (cap_row)
  );

  rdo_beat_mux #(.N_ROWS(N_ROWS), .N_COLS(N_COLS), .OUT_W(OUT_W)) u_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .row_data_i   (row_data),
    .cap_vld_i    (cap_vld),
    .cap_row_i    (cap_row),
    .pix_valid_o  (pix_valid_o),
    .pix_data_o   (pix_data_o),
    .pix_row_o    (pix_row_o),
    .pix_beat_o   (pix_beat_o),
    .frame_done_o (done)
  );

  assign row_addr_o     = addr;
  assign row_sel_o      = sel;
  assign out_en_o       = sel;
  assign row_rst_o      = cap_vld;
  assign row_rst_addr_o = cap_row;
  assign frame_done_o   = done;

endmodule

// File: tb/frame_readout_ctrl_tb.sv
module frame_readout_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 128;
  localparam int NC = 512;
  localparam int OW = 128;
  localparam int WD_LIMIT = 100000;

  typedef struct packed {
    logic [6:0]    row;
    logic [1:0]    beat;
    logic [OW-1:0] data;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [6:0] row_addr, row_rst_addr, pix_row;
  logic row_sel, out_en, row_rst, pix_valid, frame_done;
  logic [NC-1:0] col_data;
  logic [OW-1:0] pix_data;
  logic [1:0] pix_beat;

  logic [NC-1:0] mem [NR];
  logic [NC-1:0] ld_data [NR];
  logic ld_en = 1'b0;

  exp_t exq [$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_sel_cyc = 0;
  int last_sel_row = 0;
  logic prev_sel = 1'b0;
  logic [6:0] prev_addr = '0;
  logic prev_last = 1'b0;
  logic prev_mid = 1'b0;
  int beats_in_frame = 0;
  int ovl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_readout_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .row_addr_o(row_addr), .row_sel_o(row_sel), .out_en_o(out_en),
    .col_data_i(col_data), .row_rst_o(row_rst), .row_rst_addr_o(row_rst_addr),
    .pix_valid_o(pix_valid), .pix_data_o(pix_data), .pix_row_o(pix_row),
    .pix_beat_o(pix_beat), .frame_done_o(frame_done)
  );

  // behavioural array: rows cleared by reset pulses, exposure ORs bits in
  assign col_data = (row_sel && out_en) ? mem[row_addr] : '0;

  always @(posedge clk) begin
    for (int r = 0; r < NR; r++) begin
      if (!rst_n) mem[r] <= '0;
      else if (row_rst && row_rst_addr == 7'(r)) mem[r] <= '0;
      else if (ld_en) mem[r] <= mem[r] | ld_data[r];
    end
  end

  function automatic logic [NC-1:0] pat(int r, int s);
    logic [NC-1:0] v;
    logic [31:0] w;
    for (int j = 0; j < NC/32; j++) begin
      w = 32'(r) * 32'h9E3779B1 ^ 32'(j) * 32'h85EBCA6B ^ 32'(s) * 32'hC2B2AE35;
      w = w ^ (w >> 13) ^ (w << 7);
      v[j*32 +: 32] = w;
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [OW-1:0] act,
                     input logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n) begin
      if (prev_sel)
        chk(row_rst && row_rst_addr == prev_addr, "R5 reset pulse",
            {row_rst, row_rst_addr}, {1'b1, prev_addr});
      else if (row_rst)
        chk(1'b0, "R5 stray reset", 1, 0);
      if (row_sel) begin
        if (row_addr != 0)
          chk(cyc - last_sel_cyc == 4 && int'(row_addr) == last_sel_row + 1,
              "R3 select spacing", cyc - last_sel_cyc, 4);
        last_sel_cyc = cyc;
        last_sel_row = int'(row_addr);
      end
      chk(frame_done == prev_last, "R7 done timing", frame_done, prev_last);
      if (prev_mid)
        chk(pix_valid, "R6 contiguous beats", pix_valid, 1);
      if (row_sel && pix_valid) ovl++;
      if (pix_valid) begin
        exp_t e;
        beats_in_frame++;
        if (pix_beat == 0)
          chk(cyc - last_sel_cyc == 2, "R4 beat0 latency", cyc - last_sel_cyc, 2);
        if (exq.size() == 0) chk(1'b0, "R4 unexpected beat", pix_data, 0);
        else begin
          e = exq.pop_front();
          chk(pix_row == e.row && pix_beat == e.beat, "R4 row/beat tag",
              {pix_row, pix_beat}, {e.row, e.beat});
          chk(pix_data == e.data, "R4 beat data", pix_data, e.data);
        end
      end
      prev_last = pix_valid && pix_row == 7'd127 && pix_beat == 2'd3;
      prev_mid  = pix_valid && !prev_last;
      prev_sel  = row_sel;
      prev_addr = row_addr;
    end
  end

  task automatic load(input int s, input int nrows);
    @(negedge clk);
    for (int r = 0; r < NR; r++) ld_data[r] = (r < nrows) ? pat(r, s) : '0;
    ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic push_expected(input int s, input int nrows);
    for (int r = 0; r < NR; r++)
      for (int b = 0; b < NC/OW; b++) begin
        exp_t e;
        logic [NC-1:0] v;
        v = (r < nrows) ? pat(r, s) : '0;
        e.row = 7'(r); e.beat = 2'(b); e.data = v[b*OW +: OW];
        exq.push_back(e);
      end
  endtask

  task automatic kick();
    beats_in_frame = 0;
    ovl = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(row_sel && out_en && row_addr == 0, "R2 start selects row 0",
        {row_sel, out_en, row_addr}, {2'b11, 7'd0});
  endtask

  task automatic finish_frame(input bit restart_in_done);
    while (!frame_done) @(negedge clk);
    if (restart_in_done) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(beats_in_frame == 512, "R8 beats per frame", beats_in_frame, 512);
    chk(ovl > 0, "R6 select overlaps transfer", ovl, 1);
    chk(exq.size() == 0, "R4 all beats seen", exq.size(), 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!row_sel && !pix_valid, "R8 idle after frame", {row_sel, pix_valid}, 0);
    end
  endtask

  initial begin
    for (int r = 0; r < NR; r++) ld_data[r] = '0;
    repeat (3) @(negedge clk);
    chk(!row_sel && !out_en && !row_rst && !pix_valid && !frame_done, "R1 in reset",
        {row_sel, out_en, row_rst, pix_valid, frame_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!row_sel && !out_en && !row_rst && !pix_valid && !frame_done, "R1 after reset",
        {row_sel, out_en, row_rst, pix_valid, frame_done}, 0);

    // frame A: distinct pattern, stray starts mid-frame and in done cycle
    load(1, NR);
    push_expected(1, NR);
    kick();
    repeat (100) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (150) @(negedge clk);
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    finish_frame(1'b1);

    // frame B: no exposure, every row was reset after its read
    push_expected(0, 0);
    kick();
    finish_frame(1'b0);

    // frame C: fresh pattern; exposure of already-read rows during readout
    load(2, NR);
    push_expected(2, NR);
    kick();
    while (!(pix_valid && pix_row == 7'd20)) @(negedge clk);
    load(3, 10);
    finish_frame(1'b0);

    // frame D: only the rows exposed during frame C carry data
    push_expected(3, 10);
    kick();
    finish_frame(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule